// File: doc/BRIEF.md
# Branch Target Buffer Lookup Unit

This block is a small fully associative cache of branch sites used by an instruction fetch stage. Each slot records the address of a branch, the address that followed it the last time it was taken, and one direction bit. In every cycle the current fetch address is compared with all stored branch addresses at once. If a valid slot matches and its direction bit says taken, the stored target becomes the next fetch address. In every other case the next fetch address is the fetch address plus the instruction size.

The execute stage reports each branch once it has been resolved. The report carries the branch address, its real direction and target, and the prediction that fetch made for it. When the branch is already in the table, the slot is corrected from the report. When it is not in the table, a slot is claimed for it. A mispredict flag is raised in the same cycle as the report, so the pipeline can flush.

Top module: `btb_lookup_unit`

## Requirements
- R1: A synchronous active-low reset marks every slot invalid. From the first cycle after reset, every lookup misses (`pred_hit`=0, `pred_taken`=0).
- R2: A lookup is combinational. When `fetch_pc` equals the branch address of a valid slot whose direction bit is 1, `pred_hit`=1, `pred_taken`=1, and `pred_next_pc` is that slot's stored target.
- R3: On a miss, or on a hit whose direction bit is 0, `pred_next_pc` = `fetch_pc` + 4 modulo 2^32. In that case `pred_taken`=0.
- R4: A report (`rslv_valid`=1) for an address that is not in the table writes a valid slot holding `rslv_pc`, `rslv_target` and `rslv_taken`. Lookups see the new slot only after the next rising clock edge. A lookup in the same cycle as the report sees the old contents.
- R5: A report for an address that is already in the table sets that slot's direction bit to `rslv_taken`. If `rslv_taken`=1, it also replaces the stored target with `rslv_target`. It claims no further slot.
- R6: A new branch goes into the lowest-numbered invalid slot. When all 8 slots are valid, it goes into the slot named by a rotating pointer. The pointer starts at slot 0 after reset and advances by one, wrapping from 7 to 0, after each such replacement. As a result, branches are evicted in the order in which they were inserted.
- R7: `rslv_mispredict` = `rslv_valid` AND (`rslv_taken` != `rslv_pred_taken` OR (`rslv_taken`=1 AND `rslv_target` != `rslv_pred_target`)). It is combinational in the same cycle as the report.
- R8: `pred_taken`=1 only when `pred_hit`=1. No two valid slots ever hold the same branch address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_pc | input | 32 | Address being fetched this cycle |
| pred_hit | output | 1 | fetch_pc matches a valid slot |
| pred_taken | output | 1 | Matching slot predicts taken |
| pred_next_pc | output | 32 | Address to fetch next |
| rslv_valid | input | 1 | A resolved branch is reported this cycle |
| rslv_pc | input | 32 | Address of the resolved branch |
| rslv_taken | input | 1 | Real direction of the branch |
| rslv_target | input | 32 | Real target of the branch |
| rslv_pred_taken | input | 1 | Direction that fetch predicted |
| rslv_pred_target | input | 32 | Next address that fetch used |
| rslv_mispredict | output | 1 | Prediction disagreed with the outcome |

## Verification
A corrupted slot, such as a lost valid bit, a wrong stored target or a stale direction bit, shows up at the very next lookup of that branch address. It appears on `pred_hit`, `pred_taken` or `pred_next_pc`, and the output is combinational, so no cycles pass before it is visible. A rotating pointer in the wrong state cannot be seen until the table is full and a replacement happens. It then shows as the wrong branch going missing, or a live branch being lost, on the lookup after that report. For this reason the sweep checks every tracked address after every report, and it drives far more distinct branches than there are slots.

// File: rtl/btb_pkg.sv
// Package btb_pkg
// Holds the address width of the branch target buffer and the layout of one
// table slot, shared by the storage, compare and top-level logic.
package btb_pkg;

    parameter int unsigned BTB_PC_W = 32;

    // One table slot: validity, branch site, stored target, direction bit
    typedef struct packed {
        logic                valid;
        logic [BTB_PC_W-1:0] br_pc;
        logic [BTB_PC_W-1:0] tgt_pc;
        logic                dir_taken;
    } btb_slot_t;

    // Index width that stays legal for a one-slot table
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/btb_slot_cam.sv
// Module btb_slot_cam
// Compares a key address against every slot of the table in parallel.
// Returns the per-slot match vector, a hit flag and the index of the
// lowest-numbered matching slot.
// Assumes that at most one valid slot holds any given address. The priority
// encoder only makes the index well defined if that is ever not so.
module btb_slot_cam #(
    parameter int unsigned ENTRIES = 8,
    localparam int unsigned IDX_W  = btb_pkg::idx_width(ENTRIES)
) (
    input  logic [btb_pkg::BTB_PC_W-1:0] key_i,
    input  btb_pkg::btb_slot_t           slots_i [ENTRIES],
    output logic [ENTRIES-1:0]           match_o,
    output logic                         hit_o,
    output logic [IDX_W-1:0]             idx_o
);

    // One comparator per slot
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_o[g] = slots_i[g].valid && (slots_i[g].br_pc == key_i);
    end

    assign hit_o = |match_o;

    // Lowest-index match wins
    always_comb begin
        idx_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_o[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/btb_victim_sel.sv
// Module btb_victim_sel
// Chooses the slot that a newly seen branch will occupy. The lowest invalid
// slot is chosen first. Once every slot is valid, a rotating pointer names
// the slot, and the pointer moves on after each such replacement.
// Assumes that alloc_i is high only in a cycle in which a new slot is
// actually written.
module btb_victim_sel #(
    parameter int unsigned ENTRIES = 8,
    localparam int unsigned IDX_W  = btb_pkg::idx_width(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_i,
    input  logic               alloc_i,
    output logic [IDX_W-1:0]   victim_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             table_full;

    assign table_full = &valid_i;

    // Lowest-numbered invalid slot
    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_i[i]) begin
                free_idx = IDX_W'(i);
            end
        end
    end

    assign victim_o = table_full ? rr_q : free_idx;

    // Rotating pointer moves only when a full table loses a slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (alloc_i && table_full) begin
            rr_q <= (rr_q == LAST_IDX) ? '0 : rr_q + 1'b1;
        end
    end

endmodule

// File: rtl/btb_slot_store.sv
// Module btb_slot_store
// Register array that holds the table slots. At most one slot is written per
// clock. Reset clears every slot, which leaves all of them invalid.
// Assumes that wr_idx_i is below ENTRIES whenever wr_en_i is high.
module btb_slot_store #(
    parameter int unsigned ENTRIES = 8,
    localparam int unsigned IDX_W  = btb_pkg::idx_width(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [IDX_W-1:0]   wr_idx_i,
    input  btb_pkg::btb_slot_t wr_slot_i,
    output btb_pkg::btb_slot_t slots_o [ENTRIES],
    output logic [ENTRIES-1:0] valid_o
);

    btb_pkg::btb_slot_t slot_q [ENTRIES];

    // Clear on reset, otherwise write the addressed slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                slot_q[i] <= '0;
            end
        end else if (wr_en_i) begin
            slot_q[wr_idx_i] <= wr_slot_i;
        end
    end

    // Expose slot contents and the valid vector
    for (genvar g = 0; g < ENTRIES; g++) begin : g_out
        assign slots_o[g] = slot_q[g];
        assign valid_o[g] = slot_q[g].valid;
    end

endmodule

// File: rtl/btb_lookup_unit.sv
// Module btb_lookup_unit
// Fully associative branch target buffer. It has a combinational lookup port
// for fetch and a resolve port from execute. The resolve port corrects slots
// that are already present and claims a slot for each branch not yet present.
// It also flags a mispredict in the same cycle as the report.
// Assumes one report per cycle at most. A write lands at the next clock edge,
// so a lookup in the same cycle sees the old table.
module btb_lookup_unit #(
    parameter int unsigned ENTRIES    = 8,
    parameter int unsigned INST_BYTES = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [btb_pkg::BTB_PC_W-1:0] fetch_pc,
    output logic                         pred_hit,
    output logic                         pred_taken,
    output logic [btb_pkg::BTB_PC_W-1:0] pred_next_pc,
    input  logic                         rslv_valid,
    input  logic [btb_pkg::BTB_PC_W-1:0] rslv_pc,
    input  logic                         rslv_taken,
    input  logic [btb_pkg::BTB_PC_W-1:0] rslv_target,
    input  logic                         rslv_pred_taken,
    input  logic [btb_pkg::BTB_PC_W-1:0] rslv_pred_target,
    output logic                         rslv_mispredict
);

    localparam int unsigned PC_W  = btb_pkg::BTB_PC_W;
    localparam int unsigned IDX_W = btb_pkg::idx_width(ENTRIES);

    btb_pkg::btb_slot_t slots [ENTRIES];
    logic [ENTRIES-1:0] slot_valid;

    logic [ENTRIES-1:0] fetch_match;
    logic               fetch_hit;
    logic [IDX_W-1:0]   fetch_idx;

    logic [ENTRIES-1:0] rslv_match;
    logic               rslv_hit;
    logic [IDX_W-1:0]   rslv_idx;

    logic [IDX_W-1:0]   victim_idx;
    logic               alloc_new;
    logic               wr_en;
    logic [IDX_W-1:0]   wr_idx;
    btb_pkg::btb_slot_t wr_slot;

    logic [PC_W-1:0]    seq_pc;
    logic               dir_wrong;
    logic               tgt_wrong;

    btb_slot_store #(.ENTRIES(ENTRIES)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_slot_i (wr_slot),
        .slots_o   (slots),
        .valid_o   (slot_valid)
    );

    btb_slot_cam #(.ENTRIES(ENTRIES)) u_fetch_cam (
        .key_i   (fetch_pc),
        .slots_i (slots),
        .match_o (fetch_match),
        .hit_o   (fetch_hit),
        .idx_o   (fetch_idx)
    );

    btb_slot_cam #(.ENTRIES(ENTRIES)) u_rslv_cam (
        .key_i   (rslv_pc),
        .slots_i (slots),
        .match_o (rslv_match),
        .hit_o   (rslv_hit),
        .idx_o   (rslv_idx)
    );

    btb_victim_sel #(.ENTRIES(ENTRIES)) u_victim (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid_i  (slot_valid),
        .alloc_i  (alloc_new),
        .victim_o (victim_idx)
    );

    // Fetch side: pick the stored target or the sequential address
    assign seq_pc = fetch_pc + PC_W'(INST_BYTES);

    always_comb begin
        pred_hit     = fetch_hit;
        pred_taken   = fetch_hit && slots[fetch_idx].dir_taken;
        pred_next_pc = pred_taken ? slots[fetch_idx].tgt_pc : seq_pc;
    end

    // Resolve side: correct a present slot or build a new one
    assign alloc_new = rslv_valid && !rslv_hit;
    assign wr_en     = rslv_valid;

    always_comb begin
        if (rslv_hit) begin
            wr_idx            = rslv_idx;
            wr_slot           = slots[rslv_idx];
            wr_slot.dir_taken = rslv_taken;
            if (rslv_taken) begin
                wr_slot.tgt_pc = rslv_target;
            end
        end else begin
            wr_idx            = victim_idx;
            wr_slot.valid     = 1'b1;
            wr_slot.br_pc     = rslv_pc;
            wr_slot.tgt_pc    = rslv_target;
            wr_slot.dir_taken = rslv_taken;
        end
    end

    // Mispredict: wrong direction, or taken with the wrong target
    assign dir_wrong       = rslv_taken != rslv_pred_taken;
    assign tgt_wrong       = rslv_taken && (rslv_target != rslv_pred_target);
    assign rslv_mispredict = rslv_valid && (dir_wrong || tgt_wrong);

endmodule

// File: rtl/btb_lookup_unit_chk.sv
// Module btb_lookup_unit_chk
// Assertion checker bound to btb_lookup_unit. It observes the ports and the
// match vectors of the two compare units.
module btb_lookup_unit_chk #(
    parameter int unsigned ENTRIES    = 8,
    parameter int unsigned INST_BYTES = 4,
    localparam int unsigned PC_W      = btb_pkg::BTB_PC_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic [PC_W-1:0]    fetch_pc,
    input logic               pred_hit,
    input logic               pred_taken,
    input logic [PC_W-1:0]    pred_next_pc,
    input logic               rslv_valid,
    input logic [PC_W-1:0]    rslv_pc,
    input logic               rslv_taken,
    input logic [PC_W-1:0]    rslv_target,
    input logic               rslv_mispredict,
    input logic [ENTRIES-1:0] fetch_match,
    input logic [ENTRIES-1:0] rslv_match
);

    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !pred_hit);

    // R3
    seq_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_taken |-> pred_next_pc == fetch_pc + PC_W'(INST_BYTES));

    // R8
    taken_has_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken |-> pred_hit);

    // R8
    fetch_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fetch_match));

    // R8
    rslv_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rslv_match));

    // R7
    mispredict_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rslv_valid |-> !rslv_mispredict);

    // R4
    learn_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rslv_valid) && fetch_pc == $past(rslv_pc))
        |-> (pred_hit && pred_taken == $past(rslv_taken)));

    // R5
    learn_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rslv_valid) && $past(rslv_taken)
         && fetch_pc == $past(rslv_pc))
        |-> pred_next_pc == $past(rslv_target));

endmodule

bind btb_lookup_unit btb_lookup_unit_chk #(
    .ENTRIES    (ENTRIES),
    .INST_BYTES (INST_BYTES)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .fetch_pc        (fetch_pc),
    .pred_hit        (pred_hit),
    .pred_taken      (pred_taken),
    .pred_next_pc    (pred_next_pc),
    .rslv_valid      (rslv_valid),
    .rslv_pc         (rslv_pc),
    .rslv_taken      (rslv_taken),
    .rslv_target     (rslv_target),
    .rslv_mispredict (rslv_mispredict),
    .fetch_match     (fetch_match),
    .rslv_match      (rslv_match)
);

// File: tb/btb_lookup_unit_bench.sv
// Bench for btb_lookup_unit: directed cases followed by a long sweep. The
// expected table contents are kept in a model built from the requirements.
module btb_lookup_unit_bench;

    localparam int NS = 8;
    localparam int NA = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        pred_hit;
    logic        pred_taken;
    logic [31:0] pred_next_pc;
    logic        rslv_valid = 1'b0;
    logic [31:0] rslv_pc = '0;
    logic        rslv_taken = 1'b0;
    logic [31:0] rslv_target = '0;
    logic        rslv_pred_taken = 1'b0;
    logic [31:0] rslv_pred_target = '0;
    logic        rslv_mispredict;

    int n_cmp = 0;
    int n_bad = 0;

    // Model of the table
    logic        m_v [NS];
    logic [31:0] m_a [NS];
    logic [31:0] m_t [NS];
    logic        m_b [NS];
    int          m_ptr;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    btb_lookup_unit u_btb_lookup_unit (
        .clk              (clk),
        .rst_n            (rst_n),
        .fetch_pc         (fetch_pc),
        .pred_hit         (pred_hit),
        .pred_taken       (pred_taken),
        .pred_next_pc     (pred_next_pc),
        .rslv_valid       (rslv_valid),
        .rslv_pc          (rslv_pc),
        .rslv_taken       (rslv_taken),
        .rslv_target      (rslv_target),
        .rslv_pred_taken  (rslv_pred_taken),
        .rslv_pred_target (rslv_pred_target),
        .rslv_mispredict  (rslv_mispredict)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] addr_of(input int i);
        return 32'h0000_2000 + 32'(i) * 32'h40;
    endfunction

    // Model lookup: hit flag, direction bit, stored target
    task automatic m_look(input logic [31:0] pc, output logic hit,
                          output logic dir, output logic [31:0] tgt);
        hit = 1'b0; dir = 1'b0; tgt = '0;
        for (int i = NS - 1; i >= 0; i--) begin
            if (m_v[i] && m_a[i] == pc) begin
                hit = 1'b1; dir = m_b[i]; tgt = m_t[i];
            end
        end
    endtask

    task automatic m_resolve(input logic [31:0] pc, input logic tk,
                             input logic [31:0] tg);
        int slot;
        slot = -1;
        for (int i = 0; i < NS; i++) begin
            if (slot < 0 && m_v[i] && m_a[i] == pc) slot = i;
        end
        if (slot >= 0) begin
            m_b[slot] = tk;
            if (tk) m_t[slot] = tg;
        end else begin
            for (int i = 0; i < NS; i++) begin
                if (slot < 0 && !m_v[i]) slot = i;
            end
            if (slot < 0) begin
                slot = m_ptr;
                m_ptr = (m_ptr + 1) % NS;
            end
            m_v[slot] = 1'b1; m_a[slot] = pc; m_t[slot] = tg; m_b[slot] = tk;
        end
    endtask

    // Drive a lookup and compare all three fetch outputs with the model
    task automatic look(input logic [31:0] pc, input string req);
        logic h, d;
        logic [31:0] t;
        fetch_pc = pc;
        #2;
        m_look(pc, h, d, t);
        chk(req, "pred_hit", 32'(pred_hit), 32'(h));
        chk(req, "pred_taken", 32'(pred_taken), 32'(h && d));
        chk(req, "pred_next_pc", pred_next_pc, (h && d) ? t : pc + 32'd4);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        rslv_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NS; i++) begin
            m_v[i] = 1'b0; m_a[i] = '0; m_t[i] = '0; m_b[i] = 1'b0;
        end
        m_ptr = 0;
    endtask

    // One report: check the same-cycle mispredict flag and the old-view
    // lookup, then let the clock edge write the table
    task automatic report(input logic [31:0] pc, input logic tk,
                          input logic [31:0] tg, input logic ptk,
                          input logic [31:0] ptg);
        logic expm;
        @(negedge clk);
        rslv_valid = 1'b1; rslv_pc = pc; rslv_taken = tk;
        rslv_target = tg; rslv_pred_taken = ptk; rslv_pred_target = ptg;
        expm = (tk != ptk) || (tk && tg != ptg);
        look(pc, "R4 same-cycle old view");
        chk("R7", "rslv_mispredict", 32'(rslv_mispredict), 32'(expm));
        @(posedge clk);
        #1;
        rslv_valid = 1'b0;
        m_resolve(pc, tk, tg);
    endtask

    function automatic logic [31:0] step(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    initial begin
        #1_000_000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic h, d;
        logic [31:0] t;
        do_reset();

        // R1 and R3: empty table, sequential next address, wrap at the top
        look(32'h0000_0100, "R1 empty after reset");
        look(32'h0000_2000, "R1 empty after reset");
        look(32'hFFFF_FFFC, "R3 wrap of plus-four");
        chk("R3", "wrap value", pred_next_pc, 32'h0000_0000);

        // R4 and R2: a new taken branch becomes visible after the edge
        report(32'h0000_0100, 1'b1, 32'h0000_0400, 1'b0, 32'h0000_0104);
        look(32'h0000_0100, "R2 taken hit");
        chk("R2", "stored target", pred_next_pc, 32'h0000_0400);

        // R5: the same branch turns not taken, the direction bit follows
        report(32'h0000_0100, 1'b0, 32'h0000_0400, 1'b1, 32'h0000_0400);
        look(32'h0000_0100, "R5 bit cleared R3 not-taken hit");
        chk("R3", "not-taken hit next", pred_next_pc, 32'h0000_0104);

        // R5: taken again with a new target, which replaces the old one
        report(32'h0000_0100, 1'b1, 32'h0000_0800, 1'b0, 32'h0000_0104);
        look(32'h0000_0100, "R5 target refresh");
        chk("R5", "new target", pred_next_pc, 32'h0000_0800);

        // R7: full truth sweep of direction and target agreement
        for (int c = 0; c < 8; c++) begin
            m_look(32'h0000_0100, h, d, t);
            report(32'h0000_0100, c[0], c[2] ? t : t + 32'h10, c[1],
                   t);
        end

        // R6: fill all slots, then evictions follow insertion order
        do_reset();
        for (int i = 0; i < NS + 3; i++) begin
            report(addr_of(i), 1'b1, 32'h0000_9000 + 32'(i), 1'b0, addr_of(i) + 4);
            for (int j = 0; j < NS + 3; j++) look(addr_of(j), "R6 replacement order");
        end
        look(addr_of(0), "R6 oldest evicted");
        chk("R6", "first branch gone", 32'(pred_hit), 32'd0);
        look(addr_of(NS), "R6 newest present");
        chk("R6", "ninth branch present", 32'(pred_hit), 32'd1);

        // R2 R4 R5 R6 R7 R8: long sweep, every tracked address checked each time
        do_reset();
        for (int k = 0; k < 400; k++) begin
            logic [31:0] pc, tg, ptg;
            logic tk, ptk;
            lfsr = step(lfsr);
            pc = addr_of(int'(lfsr[7:0]) % NA);
            tk = lfsr[9];
            tg = 32'h0000_8000 + {28'd0, lfsr[11:10], 2'b00};
            m_look(pc, h, d, t);
            ptk = (h && d) ^ (lfsr[12] & lfsr[13]);
            ptg = ptk ? (h ? t : tg) : pc + 32'd4;
            report(pc, tk, tg, ptk, ptg);
            for (int j = 0; j < NA; j++) look(addr_of(j), "R2 R8 sweep");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule